// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller with Tail-Chaining

This controller sits next to a processor core and turns a set of interrupt request lines into handler entries. Each source has its own vector, so a handler never has to work out which line fired. Every source has an enable bit and a programmable priority, where a smaller number means more urgent. A request that arrives while a handler runs preempts it only if its priority is strictly more urgent. An active-level stack records the nesting and restores the previous level when each handler exits.

On a normal entry, the controller raises a stacking strobe for a fixed number of cycles so the core saves its context, and then issues the vector. The most urgent level, priority 0, skips stacking: a shadow register bank is switched in instead, and a level-0 handler cannot be preempted. When a handler exits while a qualifying request is pending, the controller issues the next vector at once. It skips the unstack and restack phases entirely. The register-saving datapath itself lies outside this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset `vec_valid_o`, `stack_o`, `unstack_o`, `shadow_o` and `active_o` are 0, and `act_prio_o` is all ones.
- R2: On each handler entry `vec_valid_o` is high for one cycle, and `vec_o` carries the index of the source being entered (source i uses vector i).
- R3: Among pending enabled sources the smallest priority value wins. On equal values the lower source index wins. The priority of source i sits in `prio_i[i*PRIO_W +: PRIO_W]`.
- R4: A source with its `en_i` bit at 0 is never entered. Its pending bit is held, and the source is entered after its enable returns to 1.
- R5: Suppose a request with nonzero priority is first sampled at edge t, and no handler is active. Then `stack_o` is high in the STACK_CYC cycles following edges t+1 through t+STACK_CYC, and `vec_valid_o` rises after edge t+STACK_CYC+1. With the defaults this is 9 cycles, within the twelve-cycle bound.
- R6: A priority-0 request is entered without stacking, with `vec_valid_o` rising after edge t+1. `shadow_o` is high while a level-0 handler is the active one.
- R7: A handler is preempted only by a pending enabled request with a strictly smaller priority value than `act_prio_o`. Equal or larger values wait.
- R8: A level-0 handler is never preempted, not even by another priority-0 request.
- R9: Tail-chaining applies when a nonzero-level handler exits and a pending enabled request beats the level below it (or no level is below). The next vector is then issued in the cycle after the exit edge, and `stack_o` and `unstack_o` stay low.
- R10: Any other exit of a nonzero-level handler raises `unstack_o` for UNSTACK_CYC cycles and restores `act_prio_o` to the previous level. Exiting a level-0 handler raises no `unstack_o`.
- R11: `exit_i` while no handler is active has no effect.
- R12: `act_prio_o` shows the priority of the innermost active handler, or all ones when none is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Request lines, sampled each cycle into pending bits |
| en_i | input | N_SRC | Per-source enable |
| prio_i | input | N_SRC*PRIO_W | Per-source priority, packed by source index |
| exit_i | input | 1 | Handler-exit strobe from the core |
| vec_valid_o | output | 1 | One-cycle pulse: first handler instruction may issue |
| vec_o | output | $clog2(N_SRC) | Vector number of the entered source |
| stack_o | output | 1 | Context save phase in progress |
| unstack_o | output | 1 | Context restore phase in progress |
| shadow_o | output | 1 | Shadow register bank in use by a level-0 handler |
| active_o | output | 1 | At least one handler is active |
| act_prio_o | output | PRIO_W | Active priority level, all ones when idle |

## Verification
The bench covers the following corner cases, and a faulty design would show each one as follows:
- Two requests with equal priority arriving in the same cycle. A design that compares with `<=` would enter the higher index.
- A request with equal priority arriving under an active handler. A non-strict comparison would nest it instead of holding it until exit.
- Handler exit with a pending request. A design that ignores tail-chaining would raise `unstack_o` and then `stack_o` instead of issuing the vector one cycle after exit. If it chained against the wrong level, it would skip a required restore.
- Level-0 handlers. A broken check would stack on entry or unstack on exit, or let a second level-0 request nest.
- Masked requests. A design that drops the pending bit would never enter the source after it is enabled.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN     = 2'd0,
    SEQ_STACK   = 2'd1,
    SEQ_UNSTACK = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_vec_arb.sv
module irq_vec_arb #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    cand_v_o,
  output logic [ID_W-1:0]         cand_id_o,
  output logic [PRIO_W-1:0]       cand_prio_o
);
  // strict compare while scanning upward keeps the lower index on ties
  always_comb begin
    cand_v_o    = 1'b0;
    cand_id_o   = '0;
    cand_prio_o = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!cand_v_o || prio_i[i*PRIO_W +: PRIO_W] < cand_prio_o)) begin
        cand_v_o    = 1'b1;
        cand_id_o   = ID_W'(i);
        cand_prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_vec_pstack.sv
module irq_vec_pstack #(
  parameter int PRIO_W = 3,
  parameter int LEVELS = 1 << PRIO_W,
  parameter int DEP_W  = $clog2(LEVELS + 1),
  parameter int IDX_W  = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              repl_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic [PRIO_W-1:0] top_o,
  output logic [PRIO_W-1:0] below_o,
  output logic              below_v_o,
  output logic [DEP_W-1:0]  depth_o
);
  logic [PRIO_W-1:0] lvl_q [LEVELS];
  logic [DEP_W-1:0]  depth_q;
  logic [DEP_W-1:0]  top_idx, below_idx;

  assign top_idx   = depth_q - DEP_W'(1);
  assign below_idx = depth_q - DEP_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < LEVELS; i++) lvl_q[i] <= '1;
    end else if (push_i) begin
      lvl_q[depth_q[IDX_W-1:0]] <= prio_i;
      depth_q <= depth_q + DEP_W'(1);
    end else if (repl_i) begin
      lvl_q[top_idx[IDX_W-1:0]] <= prio_i;
    end else if (pop_i) begin
      depth_q <= top_idx;
    end
  end

  assign top_o     = (depth_q == '0) ? '1 : lvl_q[top_idx[IDX_W-1:0]];
  assign below_v_o = depth_q >= DEP_W'(2);
  assign below_o   = below_v_o ? lvl_q[below_idx[IDX_W-1:0]] : '1;
  assign depth_o   = depth_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> depth_q < DEP_W'(LEVELS));
  // R7
  strict_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && depth_q != '0) |-> prio_i < top_o);
  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || repl_i) |-> depth_q != '0);
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
  import irq_vec_pkg::*;
#(
  parameter int PRIO_W      = 3,
  parameter int ID_W        = 3,
  parameter int STACK_CYC   = 8,
  parameter int UNSTACK_CYC = 8,
  parameter int CNT_MAX     = (STACK_CYC > UNSTACK_CYC) ? STACK_CYC : UNSTACK_CYC,
  parameter int CNT_W       = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exit_i,
  input  logic              cand_v_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] top_i,
  input  logic [PRIO_W-1:0] below_i,
  input  logic              below_v_i,
  input  logic              active_i,
  output logic              push_o,
  output logic              pop_o,
  output logic              repl_o,
  output logic [PRIO_W-1:0] new_prio_o,
  output logic              clr_v_o,
  output logic [ID_W-1:0]   clr_id_o,
  output logic              stack_o,
  output logic              unstack_o,
  output logic              vec_valid_o,
  output logic [ID_W-1:0]   vec_o
);
  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ID_W-1:0]   id_q, vec_q;
  logic              vec_valid_q;
  logic              run, do_exit, exit_shadow, do_chain, do_take;

  assign run         = state_q == SEQ_RUN;
  assign do_exit     = run && exit_i && active_i;
  assign exit_shadow = do_exit && (top_i == '0);
  // chain only out of a stacked handler: context below is already saved
  assign do_chain    = do_exit && !exit_shadow && cand_v_i &&
                       (!below_v_i || cand_prio_i < below_i);
  assign do_take     = run && !do_exit && cand_v_i &&
                       (!active_i || cand_prio_i < top_i);

  assign push_o     = do_take;
  assign repl_o     = do_chain;
  assign pop_o      = do_exit && !do_chain;
  assign new_prio_o = cand_prio_i;
  assign clr_v_o    = do_take || do_chain;
  assign clr_id_o   = cand_id_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SEQ_RUN;
      cnt_q       <= '0;
      id_q        <= '0;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      vec_valid_q <= 1'b0;
      case (state_q)
        SEQ_RUN: begin
          if (do_take) begin
            id_q <= cand_id_i;
            if (cand_prio_i == '0) begin
              vec_valid_q <= 1'b1;
              vec_q       <= cand_id_i;
            end else begin
              state_q <= SEQ_STACK;
              cnt_q   <= CNT_W'(STACK_CYC - 1);
            end
          end else if (do_chain) begin
            vec_valid_q <= 1'b1;
            vec_q       <= cand_id_i;
          end else if (do_exit && !exit_shadow) begin
            state_q <= SEQ_UNSTACK;
            cnt_q   <= CNT_W'(UNSTACK_CYC - 1);
          end
        end
        SEQ_STACK: begin
          if (cnt_q == '0) begin
            state_q     <= SEQ_RUN;
            vec_valid_q <= 1'b1;
            vec_q       <= id_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        SEQ_UNSTACK: begin
          if (cnt_q == '0) state_q <= SEQ_RUN;
          else             cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign stack_o     = state_q == SEQ_STACK;
  assign unstack_o   = state_q == SEQ_UNSTACK;
  assign vec_valid_o = vec_valid_q;
  assign vec_o       = vec_q;

  // R10
  unstack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unstack_o) |-> $past(exit_i));
  // R9
  chain_no_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_chain |=> (vec_valid_o && !stack_o && !unstack_o));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int N_SRC       = 8,
  parameter int PRIO_W      = 3,
  parameter int STACK_CYC   = 8,
  parameter int UNSTACK_CYC = 8,
  parameter int ID_W        = $clog2(N_SRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        irq_i,
  input  logic [N_SRC-1:0]        en_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic                    exit_i,
  output logic                    vec_valid_o,
  output logic [ID_W-1:0]         vec_o,
  output logic                    stack_o,
  output logic                    unstack_o,
  output logic                    shadow_o,
  output logic                    active_o,
  output logic [PRIO_W-1:0]       act_prio_o
);
  localparam int LEVELS = 1 << PRIO_W;
  localparam int DEP_W  = $clog2(LEVELS + 1);

  logic [N_SRC-1:0]  pend_q, req;
  logic              cand_v, clr_v, push, pop, repl, below_v;
  logic [ID_W-1:0]   cand_id, clr_id;
  logic [PRIO_W-1:0] cand_prio, new_prio, top, below;
  logic [DEP_W-1:0]  depth;

  // set wins over clear so a line still high at entry re-pends
  for (genvar g = 0; g < N_SRC; g++) begin : g_pend
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= (bit_q & ~(clr_v && clr_id == ID_W'(g))) | irq_i[g];
    end
    assign pend_q[g] = bit_q;
  end

  assign req = pend_q & en_i;

  irq_vec_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .req_i(req), .prio_i(prio_i),
    .cand_v_o(cand_v), .cand_id_o(cand_id), .cand_prio_o(cand_prio)
  );

  irq_vec_pstack #(.PRIO_W(PRIO_W), .LEVELS(LEVELS)) u_pstack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .pop_i(pop), .repl_i(repl), .prio_i(new_prio),
    .top_o(top), .below_o(below), .below_v_o(below_v), .depth_o(depth)
  );

  irq_vec_seq #(.PRIO_W(PRIO_W), .ID_W(ID_W),
                .STACK_CYC(STACK_CYC), .UNSTACK_CYC(UNSTACK_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .exit_i(exit_i),
    .cand_v_i(cand_v), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .top_i(top), .below_i(below), .below_v_i(below_v), .active_i(active_o),
    .push_o(push), .pop_o(pop), .repl_o(repl), .new_prio_o(new_prio),
    .clr_v_o(clr_v), .clr_id_o(clr_id),
    .stack_o(stack_o), .unstack_o(unstack_o),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  assign active_o   = depth != '0;
  assign act_prio_o = top;
  assign shadow_o   = active_o && (top == '0);

  // R5
  save_restore_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stack_o && unstack_o));
  // R4
  masked_never_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_v |-> (pend_q[clr_id] && en_i[clr_id]));
  // R8
  level0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_o && !exit_i) |=> $stable(act_prio_o));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 8;
  localparam int PW  = 3;
  localparam int SC  = 8;
  localparam int UC  = 8;

  typedef struct packed {
    logic [7:0] en;
    logic [7:0] irq;
    logic [2:0] base;
    logic [2:0] s1;
    logic [2:0] p1;
    logic [2:0] s2;
    logic [2:0] p2;
    logic [2:0] vec;
    logic       sh;
  } row_t;

  // R3 arbitration, R4 masking, R5/R6 entry timing
  localparam row_t TBL [6] = '{
    '{8'hFF, 8'h08, 3'd4, 3'd3, 3'd4, 3'd3, 3'd4, 3'd3, 1'b0},
    '{8'hFF, 8'h24, 3'd4, 3'd2, 3'd5, 3'd5, 3'd2, 3'd5, 1'b0},
    '{8'hFF, 8'h42, 3'd3, 3'd1, 3'd3, 3'd6, 3'd3, 3'd1, 1'b0},
    '{8'hEF, 8'h90, 3'd4, 3'd4, 3'd1, 3'd7, 3'd6, 3'd7, 1'b0},
    '{8'hFF, 8'h01, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b1},
    '{8'hFF, 8'h0C, 3'd4, 3'd2, 3'd0, 3'd3, 3'd1, 3'd2, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic [N-1:0]  en = '0;
  logic [N*PW-1:0] prio = '0;
  logic          exit_s = 1'b0;
  logic          vec_valid, stack_s, unstack_s, shadow_s, active_s;
  logic [2:0]    vec;
  logic [PW-1:0] act_prio;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl #(.N_SRC(N), .PRIO_W(PW), .STACK_CYC(SC), .UNSTACK_CYC(UC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .en_i(en), .prio_i(prio),
    .exit_i(exit_s), .vec_valid_o(vec_valid), .vec_o(vec),
    .stack_o(stack_s), .unstack_o(unstack_s), .shadow_o(shadow_s),
    .active_o(active_s), .act_prio_o(act_prio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N*PW-1:0] mkp(input logic [2:0] base,
      input logic [2:0] s1, input logic [2:0] p1, input logic [2:0] s2, input logic [2:0] p2);
    logic [N*PW-1:0] r;
    for (int i = 0; i < N; i++) r[i*PW +: PW] = base;
    r[s1*PW +: PW] = p1;
    r[s2*PW +: PW] = p2;
    return r;
  endfunction

  // drive one-cycle pulse at current negedge
  task automatic pulse_irq(input logic [N-1:0] m);
    irq = m;
  endtask

  task automatic wait_vec(input int lim, output int k, output logic [2:0] id, output bit saw_stack);
    k = 0; id = '0; saw_stack = 1'b0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      irq = '0;
      if (stack_s) saw_stack = 1'b1;
      if (vec_valid) begin
        k = i; id = vec;
        break;
      end
    end
  endtask

  task automatic drain();
    int idle = 0;
    en = '1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      irq = '0;
      if (exit_s) exit_s = 1'b0;
      else if (active_s && !stack_s && !unstack_s && !vec_valid) exit_s = 1'b1;
      if (!active_s && !stack_s && !unstack_s && !exit_s) idle++;
      else idle = 0;
      if (idle >= 6) break;
    end
    exit_s = 1'b0;
  endtask

  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      irq = '0;
      if (vec_valid || stack_s) hits++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k, hits, cnt;
    logic [2:0] id;
    bit ss;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!vec_valid, "R1 vec_valid", int'(vec_valid), 0);
    chk(!stack_s && !unstack_s, "R1 stack/unstack", int'({stack_s, unstack_s}), 0);
    chk(!active_s && !shadow_s, "R1 active/shadow", int'({active_s, shadow_s}), 0);
    chk(act_prio == 3'd7, "R1 act_prio", int'(act_prio), 7);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 idle level
    chk(act_prio == 3'd7, "R12 idle act_prio", int'(act_prio), 7);

    foreach (TBL[r]) begin
      en = TBL[r].en;
      prio = mkp(TBL[r].base, TBL[r].s1, TBL[r].p1, TBL[r].s2, TBL[r].p2);
      @(negedge clk);
      pulse_irq(TBL[r].irq);
      wait_vec(40, k, id, ss);
      // R2 R3 R4 vector selection
      chk(id == TBL[r].vec, "R2/R3/R4 table vector", int'(id), int'(TBL[r].vec));
      // R5 R6 latency and stacking
      chk(k == (TBL[r].sh ? 2 : SC + 2), "R5/R6 table latency", k, TBL[r].sh ? 2 : SC + 2);
      chk(ss == !TBL[r].sh, "R5/R6 table stacking", int'(ss), int'(!TBL[r].sh));
      drain();
    end

    // R4: masked source waits with pending held
    prio = mkp(3'd4, 3'd0, 3'd4, 3'd0, 3'd4);
    en = 8'hF7;
    @(negedge clk);
    pulse_irq(8'h08);
    quiet(30, hits);
    chk(hits == 0, "R4 masked no entry", hits, 0);
    en = 8'hFF;
    wait_vec(40, k, id, ss);
    chk(k != 0 && id == 3'd3, "R4 held pend entered", int'(id), 3);
    drain();

    // R7 nesting, R9 tail-chain, R10 restore
    prio = mkp(3'd4, 3'd2, 3'd2, 3'd6, 3'd2);
    en = 8'hFF;
    @(negedge clk);
    pulse_irq(8'h20);
    wait_vec(40, k, id, ss);
    chk(id == 3'd5, "R2 outer vector", int'(id), 5);
    chk(act_prio == 3'd4, "R12 outer level", int'(act_prio), 4);
    pulse_irq(8'h04);
    wait_vec(40, k, id, ss);
    chk(id == 3'd2 && ss, "R7 preempt with stacking", int'(id), 2);
    chk(act_prio == 3'd2, "R12 nested level", int'(act_prio), 2);
    pulse_irq(8'h40);
    quiet(20, hits);
    chk(hits == 0, "R7 equal priority waits", hits, 0);
    exit_s = 1'b1;
    @(negedge clk);
    exit_s = 1'b0;
    chk(vec_valid && vec == 3'd6, "R9 tail-chain vector", int'(vec), 6);
    chk(!stack_s && !unstack_s, "R9 no unstack/restack", int'({stack_s, unstack_s}), 0);
    chk(act_prio == 3'd2, "R9 chained level", int'(act_prio), 2);
    @(negedge clk);
    exit_s = 1'b1;
    @(negedge clk);
    exit_s = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (unstack_s) cnt++;
      @(negedge clk);
    end
    chk(cnt == UC, "R10 unstack length", cnt, UC);
    chk(act_prio == 3'd4 && active_s, "R10 level restored", int'(act_prio), 4);
    exit_s = 1'b1;
    @(negedge clk);
    exit_s = 1'b0;
    repeat (UC + 2) @(negedge clk);
    chk(!active_s && act_prio == 3'd7, "R10 back to idle", int'(act_prio), 7);

    // R6 R8 level 0 shadow, not preemptable
    prio = mkp(3'd4, 3'd1, 3'd0, 3'd4, 3'd1);
    @(negedge clk);
    pulse_irq(8'h01);
    prio[0 +: PW] = 3'd0;
    wait_vec(40, k, id, ss);
    chk(id == 3'd0 && k == 2 && !ss, "R6 shadow entry", k, 2);
    chk(shadow_s, "R6 shadow_o", int'(shadow_s), 1);
    pulse_irq(8'h12);
    quiet(20, hits);
    chk(hits == 0, "R8 level0 not preempted", hits, 0);
    exit_s = 1'b1;
    @(negedge clk);
    exit_s = 1'b0;
    chk(!unstack_s, "R10 level0 exit no unstack", int'(unstack_s), 0);
    @(negedge clk);
    chk(vec_valid && vec == 3'd1, "R6 second level0 entry", int'(vec), 1);
    drain();

    // R11 exit while idle ignored
    exit_s = 1'b1;
    @(negedge clk);
    exit_s = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      if (unstack_s || active_s || vec_valid) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R11 idle exit ignored", cnt, 0);
    chk(act_prio == 3'd7, "R11 level unchanged", int'(act_prio), 7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule